// File: doc/BRIEF.md
# Sparse Token Pixel Readout

This block drains the hit pixels of a pixel array onto one serial line once an acquisition window has closed. While acquisition is active, per-pixel hit pulses set flags held inside the block. When acquisition is over and a start pulse arrives, a token walks the array in row-major order. It spends one clock on each pixel that has no hit and stops on each pixel whose flag is set.

At a hit the token loads a fixed 30-bit record for that pixel and shifts it out most significant bit first, one bit per clock, with a frame-valid strobe. The record holds the row address, the column address and the pixel's digital timestamp. The analog-stamp field and the reserved field are sent as zeros. The pixel's flag clears as its record is loaded, and the token then moves to the next pixel. After the last pixel the block gives a one-cycle done pulse, and it does so even when no pixel had a hit.

Top module: `sparse_token_readout`

## Requirements
- R1: After reset, serData, frameValid and readDone are low and every hit flag is clear, so a readout with no new hits sends no record.
- R2: A pulse on hitSetIn[p] sets the flag of pixel p only while acqActive is high. A pulse while acqActive is low is ignored.
- R3: A startReadout pulse with acqActive low starts a scan. A start while acqActive is high is ignored, and so is a start while a scan is running.
- R4: The scan visits pixels in row-major order with the column index changing fastest, where pixel p = row*NUM_COLS + col. It sends exactly one record per flagged pixel, in that order.
- R5: Each record is 30 bits, sent most significant bit first: row in bits 29:24, column in bits 23:18, timestamp in bits 17:13 (taken from tsIn[p*5 +: 5]), a zero analog field in bits 12:8 and zero reserved bits in bits 7:0.
- R6: frameValid stays high for exactly 30 consecutive cycles per record, with one record bit on serData in each of those cycles. serData is low whenever frameValid is low.
- R7: An empty pixel costs one cycle and a hit pixel costs 31 cycles. readDone is first high after the (1 + N + 30*H)-th rising edge, counting the edge that samples startReadout as the first, where N is the pixel count and H is the hit count.
- R8: readDone is high for exactly one cycle per scan, including a scan with no hits, and is never high together with frameValid.
- R9: A flag clears when its record is loaded, so a second scan with no new hits sends no records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rstN | input | 1 | Asynchronous reset, active low |
| acqActive | input | 1 | High while the acquisition window is open |
| hitSetIn | input | NUM_ROWS*NUM_COLS | Per-pixel hit pulses, bit p for pixel p |
| tsIn | input | NUM_ROWS*NUM_COLS*TS_W | Per-pixel digital timestamps, field p at bits p*TS_W |
| startReadout | input | 1 | Single-cycle request to begin a scan |
| serData | output | 1 | Serial record data, most significant bit first |
| frameValid | output | 1 | High while a record bit is on serData |
| readDone | output | 1 | One-cycle pulse when the scan has passed the last pixel |

## Verification
The bench places hits on the first and last pixels and on whole adjacent runs of pixels. A token that mishandles the end of a row, or that fails to resume right after a record, would drop or reorder records there. It also checks the exact scan latency, which exposes a token that stalls on empty pixels or spends a spurious cycle between records.

Start pulses are sent during acquisition and in the middle of a running scan. A design that honoured either would restart the walk and resend or lose records. A second scan with no new hits shows whether flags are really cleared, since a design that left them set would resend every record.

// File: rtl/sprd_pkg.sv
package sprd_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SCAN  = 2'd1,
    RD_SHIFT = 2'd2,
    RD_DONE  = 2'd3
  } rdState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadRec;   // load the record of the pixel under the token
    logic shiftEn;   // move the record one bit towards the line
    logic clearHit;  // drop the flag of the pixel under the token
  } rdStrobes_t;

endpackage

// File: rtl/sprd_record_pack.sv
module sprd_record_pack #(
  parameter int ROW_W = 6,
  parameter int COL_W = 6,
  parameter int TS_W  = 5,
  parameter int AN_W  = 5,
  parameter int RSV_W = 8,
  parameter int REC_W = 30
) (
  input  logic [ROW_W-1:0] rowIdx,
  input  logic [COL_W-1:0] colIdx,
  input  logic [TS_W-1:0]  tsVal,
  output logic [REC_W-1:0] recWord
);

  // Address first, then time, then the fields that are carried as zero
  always_comb begin
    recWord = {rowIdx, colIdx, tsVal, {AN_W{1'b0}}, {RSV_W{1'b0}}};
  end

endmodule

// File: rtl/sprd_ctrl.sv
module sprd_ctrl
  import sprd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 6,
  parameter int COL_W    = 6,
  parameter int IDX_W    = 6,
  parameter int REC_W    = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acqActive,
  input  logic             startReadout,
  input  logic             hitAtToken,
  output rdStrobes_t       strb,
  output logic [ROW_W-1:0] rowIdx,
  output logic [COL_W-1:0] colIdx,
  output logic [IDX_W-1:0] pixIdx,
  output logic             frameValid,
  output logic             readDone
);

  localparam int CNT_W = $clog2(REC_W);

  rdState_t          state;
  logic [CNT_W-1:0]  bitCnt;
  logic              lastCol;
  logic              lastRow;
  logic              lastPix;
  logic              lastBit;
  logic [ROW_W-1:0]  nextRow;
  logic [COL_W-1:0]  nextCol;

  always_comb begin
    lastCol = (colIdx == COL_W'(NUM_COLS - 1));
    lastRow = (rowIdx == ROW_W'(NUM_ROWS - 1));
    lastPix = lastCol && lastRow;
    lastBit = (bitCnt == CNT_W'(REC_W - 1));
    nextCol = lastCol ? '0 : colIdx + 1'b1;
    nextRow = lastCol ? rowIdx + 1'b1 : rowIdx;
  end

  // The token halts on a hit: load its record and drop its flag together
  always_comb begin
    strb.loadRec  = (state == RD_SCAN) && hitAtToken;
    strb.clearHit = (state == RD_SCAN) && hitAtToken;
    strb.shiftEn  = (state == RD_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RD_IDLE;
      rowIdx <= '0;
      colIdx <= '0;
      pixIdx <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (startReadout && !acqActive) begin
            state  <= RD_SCAN;
            rowIdx <= '0;
            colIdx <= '0;
            pixIdx <= '0;
          end
        end
        RD_SCAN: begin
          if (hitAtToken) begin
            state  <= RD_SHIFT;
            bitCnt <= '0;
          end else if (lastPix) begin
            state <= RD_DONE;
          end else begin
            rowIdx <= nextRow;
            colIdx <= nextCol;
            pixIdx <= pixIdx + 1'b1;
          end
        end
        RD_SHIFT: begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) begin
            if (lastPix) begin
              state <= RD_DONE;
            end else begin
              state  <= RD_SCAN;
              rowIdx <= nextRow;
              colIdx <= nextCol;
              pixIdx <= pixIdx + 1'b1;
            end
          end
        end
        RD_DONE: state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    frameValid = (state == RD_SHIFT);
    readDone   = (state == RD_DONE);
  end

endmodule

// File: rtl/sprd_datapath.sv
module sprd_datapath
  import sprd_pkg::*;
#(
  parameter int NPIX  = 64,
  parameter int IDX_W = 6,
  parameter int ROW_W = 6,
  parameter int COL_W = 6,
  parameter int TS_W  = 5,
  parameter int AN_W  = 5,
  parameter int RSV_W = 8,
  parameter int REC_W = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 acqActive,
  input  logic [NPIX-1:0]      hitSetIn,
  input  logic [NPIX*TS_W-1:0] tsIn,
  input  rdStrobes_t           strb,
  input  logic [ROW_W-1:0]     rowIdx,
  input  logic [COL_W-1:0]     colIdx,
  input  logic [IDX_W-1:0]     pixIdx,
  output logic                 hitAtToken,
  output logic                 serData
);

  logic [NPIX-1:0]  hitFlags;
  logic [TS_W-1:0]  tsSel;
  logic [REC_W-1:0] recWord;
  logic [REC_W-1:0] shiftReg;

  // One flag per pixel: set only inside the acquisition window,
  // cleared when the token takes its record
  for (genvar g = 0; g < NPIX; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitFlags[g] <= 1'b0;
      end else if (acqActive && hitSetIn[g]) begin
        hitFlags[g] <= 1'b1;
      end else if (strb.clearHit && (pixIdx == IDX_W'(g))) begin
        hitFlags[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    hitAtToken = hitFlags[pixIdx];
    tsSel      = tsIn[int'(pixIdx)*TS_W +: TS_W];
  end

  sprd_record_pack #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .TS_W  (TS_W),
    .AN_W  (AN_W),
    .RSV_W (RSV_W),
    .REC_W (REC_W)
  ) u_pack (
    .rowIdx  (rowIdx),
    .colIdx  (colIdx),
    .tsVal   (tsSel),
    .recWord (recWord)
  );

  // Zeros fill in behind the record, so the line rests low between frames
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.loadRec) begin
      shiftReg <= recWord;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[REC_W-2:0], 1'b0};
    end
  end

  assign serData = shiftReg[REC_W-1];

endmodule

// File: rtl/sparse_token_readout.sv
module sparse_token_readout
  import sprd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 6,
  parameter int COL_W    = 6,
  parameter int TS_W     = 5,
  parameter int AN_W     = 5,
  parameter int RSV_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          acqActive,
  input  logic [NUM_ROWS*NUM_COLS-1:0]      hitSetIn,
  input  logic [NUM_ROWS*NUM_COLS*TS_W-1:0] tsIn,
  input  logic                          startReadout,
  output logic                          serData,
  output logic                          frameValid,
  output logic                          readDone
);

  localparam int NPIX  = NUM_ROWS * NUM_COLS;
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam int REC_W = ROW_W + COL_W + TS_W + AN_W + RSV_W;

  rdStrobes_t        strb;
  logic [ROW_W-1:0]  rowIdx;
  logic [COL_W-1:0]  colIdx;
  logic [IDX_W-1:0]  pixIdx;
  logic              hitAtToken;

  sprd_ctrl #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .IDX_W    (IDX_W),
    .REC_W    (REC_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .acqActive    (acqActive),
    .startReadout (startReadout),
    .hitAtToken   (hitAtToken),
    .strb         (strb),
    .rowIdx       (rowIdx),
    .colIdx       (colIdx),
    .pixIdx       (pixIdx),
    .frameValid   (frameValid),
    .readDone     (readDone)
  );

  sprd_datapath #(
    .NPIX  (NPIX),
    .IDX_W (IDX_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .TS_W  (TS_W),
    .AN_W  (AN_W),
    .RSV_W (RSV_W),
    .REC_W (REC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .acqActive  (acqActive),
    .hitSetIn   (hitSetIn),
    .tsIn       (tsIn),
    .strb       (strb),
    .rowIdx     (rowIdx),
    .colIdx     (colIdx),
    .pixIdx     (pixIdx),
    .hitAtToken (hitAtToken),
    .serData    (serData)
  );

endmodule

// File: rtl/sparse_token_readout_chk.sv
module sparse_token_readout_chk #(
  parameter int REC_W = 30
) (
  input logic clk,
  input logic rstN,
  input logic acqActive,
  input logic serData,
  input logic frameValid,
  input logic readDone
);

  localparam int RUN_W = $clog2(REC_W + 1) + 1;

  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           runCnt <= '0;
    else if (frameValid) runCnt <= runCnt + 1'b1;
    else                 runCnt <= '0;
  end

  AST_FRAME_LEN_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameValid) |-> (runCnt == RUN_W'(REC_W))); // R6

  AST_FRAME_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (runCnt < RUN_W'(REC_W))); // R6

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> !serData); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    readDone |=> !readDone); // R8

  AST_DONE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !(readDone && frameValid)); // R8

  AST_NO_FRAME_IN_ACQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameValid) |-> !acqActive); // R3

endmodule

bind sparse_token_readout sparse_token_readout_chk #(.REC_W(REC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .acqActive  (acqActive),
  .serData    (serData),
  .frameValid (frameValid),
  .readDone   (readDone)
);

// File: tb/sparse_token_readout_tb.sv
module sparse_token_readout_tb;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int NPIX = ROWS * COLS;
  localparam int TSW  = 5;
  localparam int RECW = 30;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 acqActive = 1'b0;
  logic [NPIX-1:0]      hitSetIn = '0;
  logic [NPIX*TSW-1:0]  tsIn = '0;
  logic                 startReadout = 1'b0;
  logic                 serData;
  logic                 frameValid;
  logic                 readDone;

  int checks = 0;
  int errors = 0;

  logic [RECW-1:0] gotQ[$];
  logic [RECW-1:0] monWord = '0;
  int monRun = 0;
  int doneCnt = 0;
  int quietBad = 0;

  always #5 clk = ~clk;

  sparse_token_readout u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .acqActive    (acqActive),
    .hitSetIn     (hitSetIn),
    .tsIn         (tsIn),
    .startReadout (startReadout),
    .serData      (serData),
    .frameValid   (frameValid),
    .readDone     (readDone)
  );

  task automatic check(bit ok, string tag, longint got, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [TSW-1:0] tsOf(int p);
    return TSW'((p * 7 + 3) % 32);
  endfunction

  function automatic logic [RECW-1:0] expRec(int p);
    return {6'(p / COLS), 6'(p % COLS), tsOf(p), 13'b0};
  endfunction

  // Serial monitor: gathers frames and the done pulses
  always @(negedge clk) begin
    if (rstN) begin
      if (readDone) doneCnt++;
      if (frameValid) begin
        monWord = {monWord[RECW-2:0], serData};
        monRun++;
      end else begin
        if (serData) quietBad++;
        if (monRun != 0) begin
          check(monRun == RECW, "R6 frame length", monRun, RECW);
          gotQ.push_back(monWord);
          monRun = 0;
        end
      end
    end
  end

  task automatic loadHits(logic [NPIX-1:0] mask, bit acq);
    @(negedge clk);
    acqActive = acq;
    hitSetIn  = mask;
    @(negedge clk);
    hitSetIn  = '0;
    acqActive = 1'b0;
  endtask

  task automatic runReadout(string tag, logic [NPIX-1:0] mask, int extraAt);
    int hits = 0;
    int cnt = 0;
    int idx = 0;
    for (int p = 0; p < NPIX; p++) if (mask[p]) hits++;
    gotQ.delete();
    doneCnt = 0;
    quietBad = 0;
    @(negedge clk);
    startReadout = 1'b1;
    while (cnt < 6000) begin
      @(posedge clk);
      #1;
      cnt++;
      startReadout = (extraAt != 0) && (cnt == extraAt);
      if (readDone) break;
    end
    startReadout = 1'b0;
    check(cnt == 1 + NPIX + 30 * hits, {tag, " R7 done latency"}, cnt, 1 + NPIX + 30 * hits);
    @(negedge clk);
    @(negedge clk);
    check(doneCnt == 1, {tag, " R8 single done"}, doneCnt, 1);
    check(readDone == 1'b0, {tag, " R8 done low after"}, readDone, 0);
    check(quietBad == 0, {tag, " R6 line quiet"}, quietBad, 0);
    check(gotQ.size() == hits, {tag, " R4 record count"}, gotQ.size(), hits);
    for (int p = 0; p < NPIX; p++) begin
      if (mask[p] && idx < gotQ.size()) begin
        check(gotQ[idx] == expRec(p), {tag, " R5 record"}, gotQ[idx], expRec(p));
        idx++;
      end
    end
  endtask

  task automatic t_reset();
    check(serData == 1'b0, "R1 serData after reset", serData, 0);
    check(frameValid == 1'b0, "R1 frameValid after reset", frameValid, 0);
    check(readDone == 1'b0, "R1 readDone after reset", readDone, 0);
    runReadout("R1 empty after reset", '0, 0);
  endtask

  task automatic t_corners();
    logic [NPIX-1:0] m = '0;
    m[0] = 1'b1;
    m[NPIX-1] = 1'b1;
    loadHits(m, 1'b1);
    runReadout("R4 corners", m, 0);
  endtask

  task automatic t_pattern();
    logic [NPIX-1:0] m = '0;
    m[5] = 1'b1; m[7] = 1'b1; m[8] = 1'b1; m[13] = 1'b1; m[40] = 1'b1;
    loadHits(m, 1'b1);
    runReadout("R4 scattered", m, 0);
    // r9_ flags were cleared by the first scan
    runReadout("R9 reread", '0, 0);
  endtask

  task automatic t_fullRow();
    logic [NPIX-1:0] m = '0;
    for (int c = 0; c < COLS; c++) m[3 * COLS + c] = 1'b1;
    loadHits(m, 1'b1);
    runReadout("R4 adjacent row", m, 0);
  endtask

  task automatic t_setIdleIgnored();
    logic [NPIX-1:0] m = '0;
    m[9] = 1'b1; m[30] = 1'b1;
    loadHits(m, 1'b0);
    runReadout("R2 set outside window", '0, 0);
  endtask

  task automatic t_startInAcq();
    logic [NPIX-1:0] m = '0;
    m[20] = 1'b1; m[63] = 1'b1;
    loadHits(m, 1'b1);
    gotQ.delete();
    doneCnt = 0;
    @(negedge clk);
    acqActive = 1'b1;
    startReadout = 1'b1;
    @(negedge clk);
    startReadout = 1'b0;
    repeat (200) @(negedge clk);
    check(doneCnt == 0, "R3 start in acquisition done", doneCnt, 0);
    check(gotQ.size() == 0, "R3 start in acquisition frames", gotQ.size(), 0);
    acqActive = 1'b0;
    runReadout("R3 hits kept after ignored start", m, 0);
  endtask

  task automatic t_startBusy();
    logic [NPIX-1:0] m = '0;
    m[2] = 1'b1; m[33] = 1'b1; m[50] = 1'b1;
    loadHits(m, 1'b1);
    runReadout("R3 start while busy", m, 45);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPIX; p++) tsIn[p * TSW +: TSW] = tsOf(p);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_corners();
    t_pattern();
    t_fullRow();
    t_setIdleIgnored();
    t_startInAcq();
    t_startBusy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule